// File: doc/BRIEF.md
# Serial addressed control latch bank

This block receives control words over a three-wire serial port (serial clock, serial data, strobe) and keeps a bank of single-bit control latches. These latches steer the paths of an audio switch matrix and a few mode settings. Each word is seven bits long: a six-bit latch address, sent most significant bit first, followed by one value bit. When the strobe rises, only the latch that the word names is set or cleared. Address zero is the exception: it clears the whole bank.

The three serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are detected on the synchronized copies. A rise of the serial clock shifts the synchronized data bit into a seven-bit shift register. A rise of the strobe commits the word. The block drives the full 64-bit latch vector, indexed by address. It also drives one derived output for the high receiver-volume boost, which is active only while both volume boost latches are set. The power-on reset comes in as an active-low input.

Top module: `ctl_latch_bank`

## Requirements
- R1: While reset is applied, and after it is released, every bit of `latch_q` is 0 and `vol_boost_hi` is 0 until the first committed word.
- R2: A word is seven serial bits, sent in this order: address bit 5 down to address bit 0, then the value bit. For example, writing address 0x26 with value 1 sends 1,0,0,1,1,0,1.
- R3: While the strobe stays low, serial clock pulses shift bits in but leave `latch_q` unchanged.
- R4: On a strobe rise with a nonzero address, bit `latch_q[address]` takes the value bit and every other bit keeps its value. This includes addresses with no assigned function.
- R5: On a strobe rise with address 0x00, all 64 latch bits are cleared, whatever the value bit.
- R6: When more than seven bits are clocked in before the strobe, only the last seven received form the word.
- R7: `vol_boost_hi` equals `latch_q[0x1F]` AND `latch_q[0x17]`.
- R8: When the strobe pin rises with setup met before a system clock edge, `latch_q` changes on the third such edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_clk | input | 1 | Serial clock pin; data is taken on its rise |
| ser_dat | input | 1 | Serial data pin |
| ser_stb | input | 1 | Strobe pin; a word is committed on its rise |
| latch_q | output | 64 | Latch vector, bit n holds address n |
| vol_boost_hi | output | 1 | High receiver-volume boost, gated by the lower boost latch |

## Verification
The bench sets every nonzero address in turn, then clears alternate ones. After each word it compares the whole vector, which catches a bit-order reversal, an off-by-one in the address field, or a decoder that disturbs a neighbouring latch. It issues the clear-all command with both value bits: a design that treats address zero as an ordinary latch would leave the bank set. It feeds in surplus leading bits, so a design that keeps the first seven bits instead of the last seven would write the wrong latch. It also shifts a whole word with the strobe held low and walks the two boost latches through all four combinations. Last, it times a commit edge by edge: a design with a missing or extra synchronizer stage would show its update one cycle early or late.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;
  localparam int unsigned DEF_ADDR_W   = 6;
  localparam int unsigned DEF_SYNC_N   = 2;
  localparam int unsigned DEF_VOL_LO   = 'h17;
  localparam int unsigned DEF_VOL_HI   = 'h1F;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_CLEAR = 2'd2
  } cmd_e;
endpackage

// File: rtl/clb_rst_sync.sv
module clb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clb_sync.sv
module clb_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = pin_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/clb_edge.sv
module clb_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb begin
    prev_d = lvl_i;
    rise_o = lvl_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_chk
    // R8: a detected rise lasts exactly one system cycle
    p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/clb_shifter.sv
module clb_shifter #(
  parameter int unsigned FRAME_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign frame_o = sr_q;

  // R2: the newest serial bit lands in the value position
  p_newest_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (frame_o[0] == $past(din)));
  // R6: older bits move up by one on every shift
  p_age_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (frame_o[FRAME_W-1:1] == $past(frame_o[FRAME_W-2:0])));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(frame_o));
endmodule

// File: rtl/clb_latch_array.sv
module clb_latch_array
  import ctl_latch_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned LATCH_N = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               val,
  output logic [LATCH_N-1:0] q_o
);
  cmd_e               cmd;
  logic [LATCH_N-1:0] sel;
  logic [LATCH_N-1:0] q_q;
  logic [LATCH_N-1:0] q_d;
  logic [LATCH_N-1:0] q_en;

  always_comb begin
    cmd = CMD_IDLE;
    if (commit) cmd = (addr == '0) ? CMD_CLEAR : CMD_WRITE;
  end

  for (genvar g = 0; g < LATCH_N; g++) begin : g_bit
    always_comb begin
      sel[g]  = (addr == ADDR_W'(g));
      q_en[g] = (cmd == CMD_CLEAR) || ((cmd == CMD_WRITE) && sel[g]);
      q_d[g]  = (cmd == CMD_CLEAR) ? 1'b0 : val;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_q[g] <= 1'b0;
      else if (q_en[g]) q_q[g] <= q_d[g];
    end
  end

  assign q_o = q_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(q_o));
  p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr != '0) |=> (q_o[$past(addr)] == $past(val)));
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr != '0) |=> ($countones(q_o ^ $past(q_o)) <= 1));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == '0) |=> (q_o == '0));
endmodule

// File: rtl/ctl_latch_bank.sv
module ctl_latch_bank
  import ctl_latch_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned SYNC_N  = DEF_SYNC_N,
  parameter int unsigned VOL_LO  = DEF_VOL_LO,
  parameter int unsigned VOL_HI  = DEF_VOL_HI,
  localparam int unsigned FRAME_W = ADDR_W + 1,
  localparam int unsigned LATCH_N = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               ser_stb,
  output logic [LATCH_N-1:0] latch_q,
  output logic               vol_boost_hi
);
  logic               rst_n_i;
  logic [2:0]         pins_s;
  logic [1:0]         rise;
  logic [FRAME_W-1:0] frame;

  clb_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  clb_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n_i),
    .pin_i({ser_stb, ser_clk, ser_dat}), .sync_o(pins_s)
  );

  clb_edge #(.WIDTH(2)) u_edge (
    .clk(clk), .rst_n(rst_n_i), .lvl_i(pins_s[2:1]), .rise_o(rise)
  );

  clb_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n_i), .shift_en(rise[0]),
    .din(pins_s[0]), .frame_o(frame)
  );

  clb_latch_array #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n_i), .commit(rise[1]),
    .addr(frame[FRAME_W-1:1]), .val(frame[0]), .q_o(latch_q)
  );

  assign vol_boost_hi = latch_q[VOL_HI] & latch_q[VOL_LO];

  p_vol_gate_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    vol_boost_hi |-> latch_q[VOL_LO]);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n_i |-> (latch_q == '0));
endmodule

// File: tb/test_ctl_latch_bank.sv
module test_ctl_latch_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_stb = 1'b0;
  logic [63:0] latch_q;
  logic        vol_boost_hi;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q = '0;

  always #4 clk = ~clk;

  ctl_latch_bank i_ctl_latch_bank (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_stb(ser_stb), .latch_q(latch_q), .vol_boost_hi(vol_boost_hi)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_dat = b;
    wait_cyc(4); ser_clk = 1'b1;
    wait_cyc(4); ser_clk = 1'b0;
  endtask

  task automatic send_word(input logic [5:0] a, input logic d);
    for (int i = 5; i >= 0; i--) send_bit(a[i]);
    send_bit(d);
  endtask

  task automatic strobe();
    wait_cyc(4); ser_stb = 1'b1;
    wait_cyc(4); ser_stb = 1'b0;
    wait_cyc(6);
  endtask

  task automatic write(input logic [5:0] a, input logic d);
    send_word(a, d);
    strobe();
    if (a == 6'd0) exp_q = '0;
    else exp_q[a] = d;
  endtask

  task automatic chk_vol(input string tag);
    chk(tag, {63'd0, vol_boost_hi}, {63'd0, exp_q[31] & exp_q[23]});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk("R1 during reset", latch_q, 64'd0);
    rst_n = 1'b1;
    wait_cyc(6);
    chk("R1 after release", latch_q, 64'd0);
    chk("R1 vol after release", {63'd0, vol_boost_hi}, 64'd0);

    // R4 and R2: set every nonzero address in ascending order
    for (int a = 1; a < 64; a++) begin
      write(6'(a), 1'b1);
      chk($sformatf("R4 set addr %0d", a), latch_q, exp_q);
      chk_vol("R7 during set sweep");
    end
    // R4: clear even addresses
    for (int a = 2; a < 64; a += 2) begin
      write(6'(a), 1'b0);
      chk($sformatf("R4 clear addr %0d", a), latch_q, exp_q);
    end

    // R7: walk both boost latches through all combinations
    for (int c = 0; c < 4; c++) begin
      write(6'h17, c[0]);
      write(6'h1F, c[1]);
      chk($sformatf("R7 combo %0d vector", c), latch_q, exp_q);
      chk_vol($sformatf("R7 combo %0d", c));
    end

    // R3: full word shifted with strobe low leaves latches untouched
    send_word(6'h05, 1'b0);
    wait_cyc(8);
    chk("R3 strobe low hold", latch_q, exp_q);
    strobe();
    exp_q[5] = 1'b0;
    chk("R3 later commit", latch_q, exp_q);

    // R5: clear-all with value bit 1
    write(6'h00, 1'b1);
    chk("R5 clear all d=1", latch_q, 64'd0);
    chk_vol("R5 vol after clear");

    // R6 and R2: three surplus bits, then sequence 1,0,0,1,1,0,1 (addr 0x26, d=1)
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    send_word(6'h26, 1'b1);
    strobe();
    exp_q[38] = 1'b1;
    chk("R6 last seven bits", latch_q, exp_q);

    write(6'h3F, 1'b1);
    write(6'h01, 1'b1);
    write(6'h00, 1'b0);
    chk("R5 clear all d=0", latch_q, 64'd0);

    // R8: commit timing relative to the strobe pin
    send_word(6'h2A, 1'b1);
    wait_cyc(4);
    @(negedge clk); ser_stb = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 before third edge", latch_q, 64'd0);
    @(posedge clk); #1;
    exp_q[42] = 1'b1;
    chk("R8 at third edge", latch_q, exp_q);
    wait_cyc(4); ser_stb = 1'b0;
    wait_cyc(6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule